// File: doc/BRIEF.md
# SPI Master with Transmit Status Flags

This block is a mode-0, MSB-first SPI master for a larger chip. Software pushes bytes into a small transmit queue. The shift engine sends them on MOSI and drives a serial clock derived from the system clock by an even divider. For every byte it sends, the engine captures one byte from MISO into a receive queue. To read from a device, software writes a dummy byte for each byte it wants back. Chip select is driven elsewhere by software.

A parallel status word reports progress. It carries a completion pulse that lasts one system clock when the queue has drained. It also carries a level-type idle flag that rises one clock after that pulse and holds until software writes again, plus queue flags and a sticky overflow bit. The completion pulse is also brought out on its own pin for an interrupt controller, since a polling reader can miss a one-cycle event. A reader that polls should wait on the idle flag instead.

Top module: `spim_master`

## Requirements
- R1: After reset the status word reads idle=1, done=0, transmit-empty=1, transmit-not-full=1, receive-not-empty=0 and overflow=0, and `sclk` is low.
- R2: Transfers use SPI mode 0, MSB first. `sclk` is low at rest, and each half period lasts CLK_DIV/2 system clocks (rising edges are CLK_DIV clocks apart). `mosi` holds steady while `sclk` is high and changes only after a falling edge.
- R3: Status bit 0 (done) is high for exactly one clock, in the clock after the last falling `sclk` edge of a byte when no further byte is queued. It is not latched, and `done_irq` carries the same pulse.
- R4: Status bit 1 (idle) rises one clock after the done pulse. It then stays high until a byte is accepted into the transmit queue.
- R5: An accepted write clears idle on the next clock, before any shifting has begun.
- R6: Each byte sent produces one received byte, sampled from `miso` on rising `sclk` edges with MSB first. Received bytes are queued in order; `rx_data` shows the oldest one and `rx_rd` removes it. A byte that arrives while the receive queue is full is dropped.
- R7: If a byte is queued when the current byte ends, the next byte starts with no idle `sclk` time, and no done pulse is generated between the two bytes.
- R8: Both queues hold 4 entries. Status bit 2 is transmit-empty, bit 3 is transmit-not-full and bit 4 is receive-not-empty. A write to a full transmit queue is dropped and sets the sticky overflow bit (bit 5), which only `clr` or reset can clear.
- R9: A `clr` pulse empties both queues, stops the engine with `sclk` low, clears overflow and sets idle. No transfer follows unless new data is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the queues, engine and overflow |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_status | output | 6 | {overflow, rx_not_empty, tx_not_full, tx_empty, idle, done} |
| done_irq | output | 1 | Completion pulse for an interrupt |

## Verification
The embedded assertions check the flag protocol on every cycle. They cover:
- the single-cycle width of done and idle following it;
- idle holding until a write, and a write clearing it;
- `sclk` resting low whenever the engine is stopped;
- `mosi` holding while `sclk` is high;
- the queue bounds.

Only the directed scenarios can show the values on the wire and in the receive queue. They compare the serialised bytes, the gap-free timing of bursts, which byte is dropped on overflow, and the behaviour of `clr` in the middle of a transfer.

// File: rtl/spim_pkg.sv
// Shared types and status-word bit positions for the SPI master.
// Assumes: status word consumers decode the fixed bit positions below.
package spim_pkg;
    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    localparam int ST_W        = 6;
    localparam int ST_DONE     = 0;
    localparam int ST_IDLE     = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_TX_NFULL = 3;
    localparam int ST_RX_NEMPT = 4;
    localparam int ST_TX_OVF   = 5;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous queue with first-word fall-through read data.
// Assumes: writes when full and reads when empty are ignored; clr empties it.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rd_ptr];

    // Store accepted data at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> full);
endmodule

// File: rtl/spim_engine.sv
// Mode-0 MSB-first shift engine with an even clock divider.
// Assumes: tx_avail/tx_byte come from a fall-through queue popped by tx_pop;
// the next byte is loaded on the final falling edge so bursts have no gap.
module spim_engine
    import spim_pkg::*;
#(
    parameter int W       = 8,
    parameter int CLK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_byte,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso,
    output logic         done
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = (W > 1) ? $clog2(W) : 1;

    eng_state_t    state;
    logic [DW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  tx_sh, rx_sh;
    logic          sclk_r, done_r;
    logic          edge_now, rise_now, fall_now, last_bit;

    // Edge strobes from the divider.
    always_comb begin
        edge_now = (state == ENG_SHIFT) && (div_cnt == DW'(HALF - 1));
        rise_now = edge_now && !sclk_r;
        fall_now = edge_now && sclk_r;
        last_bit = (bit_cnt == BW'(W - 1));
        tx_pop   = ((state == ENG_IDLE) && tx_avail) || (fall_now && last_bit && tx_avail);
        rx_push  = fall_now && last_bit;
    end

    assign rx_byte = rx_sh;
    assign sclk    = sclk_r;
    assign mosi    = tx_sh[W-1];
    assign done    = done_r;

    // Sequence bytes, divide the clock and shift both directions.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state   <= ENG_IDLE;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk_r  <= 1'b0;
            done_r  <= 1'b0;
        end else begin
            done_r <= fall_now && last_bit && !tx_avail;
            case (state)
                ENG_IDLE: begin
                    if (tx_avail) begin
                        state   <= ENG_SHIFT;
                        tx_sh   <= tx_byte;
                        div_cnt <= '0;
                        bit_cnt <= '0;
                        sclk_r  <= 1'b0;
                    end
                end
                default: begin
                    if (edge_now) begin
                        div_cnt <= '0;
                        sclk_r  <= !sclk_r;
                        if (!sclk_r) begin
                            rx_sh <= {rx_sh[W-2:0], miso};
                        end else if (last_bit) begin
                            bit_cnt <= '0;
                            if (tx_avail) tx_sh <= tx_byte;
                            else          state <= ENG_IDLE;
                        end else begin
                            bit_cnt <= bit_cnt + BW'(1);
                            tx_sh   <= {tx_sh[W-2:0], 1'b0};
                        end
                    end else begin
                        div_cnt <= div_cnt + DW'(1);
                    end
                end
            endcase
        end
    end

    p_sclk_rest_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE) |-> !sclk_r);
    p_mosi_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_r && $past(sclk_r)) |-> $stable(mosi));
    p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |=> !done_r);
    p_done_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> (state == ENG_IDLE));
endmodule

// File: rtl/spim_master.sv
// SPI master top: transmit and receive queues, shift engine, status word.
// Assumes: chip select is handled outside; done pulse feeds an interrupt.
module spim_master
    import spim_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH   = 4,
    parameter int CLK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tx_wr,
    input  logic [W-1:0]    tx_data,
    input  logic            rx_rd,
    output logic [W-1:0]    rx_data,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [ST_W-1:0] tx_status,
    output logic            done_irq
);
    logic         tx_empty, tx_full, rx_empty, rx_full;
    logic         tx_pop, rx_push, eng_done;
    logic [W-1:0] tx_head, rx_byte;
    logic         idle_r, ovf_r, wr_ok;

    assign wr_ok = tx_wr && !tx_full;

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr(rx_push), .wdata(rx_byte), .rd(rx_rd),
        .rdata(rx_data), .empty(rx_empty), .full(rx_full)
    );

    spim_engine #(.W(W), .CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .sclk(sclk), .mosi(mosi), .miso(miso), .done(eng_done)
    );

    // Idle level follows done and is cleared by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) idle_r <= 1'b1;
        else if (wr_ok)    idle_r <= 1'b0;
        else if (eng_done) idle_r <= 1'b1;
    end

    // Sticky record of a dropped transmit write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        ovf_r <= 1'b0;
        else if (tx_wr && tx_full) ovf_r <= 1'b1;
    end

    // Assemble the parallel status word.
    always_comb begin
        tx_status              = '0;
        tx_status[ST_DONE]     = eng_done;
        tx_status[ST_IDLE]     = idle_r;
        tx_status[ST_TX_EMPTY] = tx_empty;
        tx_status[ST_TX_NFULL] = !tx_full;
        tx_status[ST_RX_NEMPT] = !rx_empty;
        tx_status[ST_TX_OVF]   = ovf_r;
    end

    assign done_irq = eng_done;

    p_idle_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !tx_wr && !clr) |=> idle_r);
    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_r && !tx_wr) |=> idle_r);
    p_write_clears_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_full && !clr) |=> !idle_r);
    p_clear_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idle_r && tx_empty && rx_empty && !ovf_r && !sclk));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_r && !clr) |=> ovf_r);
endmodule

// File: tb/sim_spim_master.sv
// Directed bench for spim_master: one task per scenario.
module sim_spim_master;
    localparam int CLK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic [5:0] tx_status;
    logic       done_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spim_master #(.W(8), .DEPTH(4), .CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso),
        .tx_status(tx_status), .done_irq(done_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Writes n bytes on consecutive clocks, plays a slave, waits for done.
    task automatic run_burst(input int n, input logic [47:0] txb, input logic [47:0] slv,
                             output logic [63:0] mbits, output int rises,
                             output int span, output int dones);
        logic [47:0] sl = slv;
        logic prev = 1'b0;
        int first = -1, last = -1, done_cyc = -1, wi = 0;
        mbits = '0; rises = 0; dones = 0;
        miso = sl[47];
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (cyc == 1)
                chk(!tx_status[1], "R5", "idle after write", tx_status[1], 0);
            if (sclk && !prev) begin
                rises++;
                mbits = {mbits[62:0], mosi};
                if (first < 0) first = cyc;
                last = cyc;
            end
            if (!sclk && prev) begin
                sl = sl << 1;
                miso = sl[47];
            end
            prev = sclk;
            if (tx_status[0]) begin
                dones++;
                chk(done_irq == 1'b1, "R3", "irq with done", done_irq, 1);
                chk(!tx_status[1], "R4", "idle low during done", tx_status[1], 0);
                done_cyc = cyc;
            end
            if (done_cyc >= 0 && cyc == done_cyc + 1) begin
                chk(!tx_status[0], "R3", "done width", tx_status[0], 0);
                chk(tx_status[1], "R4", "idle after done", tx_status[1], 1);
                break;
            end
            if (wi < n) begin
                tx_wr = 1'b1;
                tx_data = txb[47 - 8*wi -: 8];
                wi++;
            end else begin
                tx_wr = 1'b0;
            end
        end
        tx_wr = 1'b0;
        span = last - first;
    endtask

    task automatic read_rx(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(tx_status[4], req, "rx not empty", tx_status[4], 1);
        chk(rx_data == exp, req, "rx byte", rx_data, exp);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_status == 6'b001110, "R1", "status after reset", tx_status, 6'b001110);
        chk(!sclk, "R1", "sclk after reset", sclk, 0);
    endtask

    task automatic t_single();
        logic [63:0] mb; int r, s, d;
        run_burst(1, {8'hA5, 40'h0}, {8'h3C, 40'h0}, mb, r, s, d);
        chk(mb[7:0] == 8'hA5, "R2", "mosi byte", mb[7:0], 8'hA5);
        chk(r == 8, "R2", "sclk rises", r, 8);
        chk(s == 7 * CLK_DIV, "R2", "rise span", s, 7 * CLK_DIV);
        chk(d == 1, "R3", "done count", d, 1);
        read_rx(8'h3C, "R6");
        repeat (5) @(negedge clk);
        chk(tx_status[1] && !tx_status[0], "R4", "idle holds", tx_status[1:0], 2'b10);
    endtask

    task automatic t_burst();
        logic [63:0] mb; int r, s, d;
        run_burst(3, {24'h5AC30F, 24'h0}, {24'h96E17B, 24'h0}, mb, r, s, d);
        chk(mb[23:0] == 24'h5AC30F, "R2", "burst mosi", mb[23:0], 24'h5AC30F);
        chk(r == 24, "R7", "burst rises", r, 24);
        chk(s == 23 * CLK_DIV, "R7", "no gap span", s, 23 * CLK_DIV);
        chk(d == 1, "R7", "one done per burst", d, 1);
        read_rx(8'h96, "R6");
        read_rx(8'hE1, "R6");
        read_rx(8'h7B, "R6");
        chk(!tx_status[4], "R6", "rx drained", tx_status[4], 0);
    endtask

    task automatic t_overflow();
        logic [63:0] mb; int r, s, d;
        run_burst(6, 48'h112233445566, 48'hA1B2C3D4E5F6, mb, r, s, d);
        chk(r == 40, "R8", "five bytes sent", r, 40);
        chk(mb[39:0] == 40'h1122334455, "R8", "dropped last write", mb[39:0], 40'h1122334455);
        chk(tx_status[5], "R8", "overflow sticky", tx_status[5], 1);
        chk(tx_status[3:2] == 2'b11, "R8", "tx empty and not full", tx_status[3:2], 2'b11);
        read_rx(8'hA1, "R6");
        read_rx(8'hB2, "R6");
        read_rx(8'hC3, "R6");
        read_rx(8'hD4, "R6");
        @(negedge clk);
        chk(!tx_status[4], "R6", "fifth rx byte dropped", tx_status[4], 0);
        chk(tx_status[5], "R8", "overflow still set", tx_status[5], 1);
    endtask

    task automatic t_clear();
        bit moved = 1'b0;
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'hF0;
        @(negedge clk); tx_data = 8'h0F;
        @(negedge clk); tx_wr = 1'b0;
        repeat (10) @(negedge clk);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(tx_status == 6'b001110, "R9", "status after clr", tx_status, 6'b001110);
        chk(!sclk, "R9", "sclk after clr", sclk, 0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sclk) moved = 1'b1;
        end
        chk(!moved, "R9", "no transfer after clr", moved, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_burst();
        t_overflow();
        t_clear();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule